// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It reads a two-level page table that sits in memory. A requester hands over an address and says whether the access is a load or a store. The walker then reads one 32-bit word from the first-level table. That word points at a second-level table, and the walker reads the leaf word from it. The leaf supplies the physical page number, and the low 12 address bits pass through unchanged. Pages are 4 KB. The virtual page number splits into a 10-bit first-level index (bits 31:22) and a 10-bit second-level index (bits 21:12).

Every table word uses the same layout:
- bit 0 marks the entry as valid.
- bit 1 marks the page as resident. When it is clear, the page lives on disk.
- bit 2 allows stores.
- bit 3 is the dirty flag.
- bits 31:12 hold the page number of the next table or of the data page.

A walk can end in one of four ways. It succeeds, or it faults because an entry is invalid, because a page is not resident, or because a store hits a page that does not allow stores. A store to a page that allows stores but is still clean first writes the leaf back with its dirty flag set, and only then responds. The walker handles one walk at a time. The table base comes in as an input and is sampled when a request is accepted.

Memory traffic goes over one request port. The walker raises a request with an address, a write flag and write data. It holds all of them steady until memory returns a one-cycle acknowledge. For a read, the acknowledge carries the data.

Top module: `pt_walker`

## Requirements
- R1: After reset, busy, done, fault and mem_req are all low, and they stay low until a request arrives.
- R2: On a successful walk, phys_addr is {leaf[31:12], va[11:0]}. For example, VA 0xFC51908B with a leaf that names page 0x00152 gives 0x0015208B.
- R3: The first memory access of a walk is a read at {base[31:12], 12'b0} + va[31:22]*4.
- R4: The second memory access is a read at {L1[31:12], 12'b0} + va[21:12]*4, where L1 is the first-level word.
- R5: An entry with bit 0 clear, at either level, ends the walk with fault_code 1. A first-level fault issues no second read.
- R6: An entry with bit 0 set and bit 1 clear, at either level, ends the walk with fault_code 2.
- R7: A store whose leaf has bit 2 clear ends with fault_code 3 and writes nothing to memory.
- R8: A store whose leaf has bit 2 set and bit 3 clear writes the leaf word with bit 3 set back to the leaf address. The walker then reports done.
- R9: A load, or a store to a leaf that is already dirty, writes nothing to memory.
- R10: busy is high from the cycle after a request is accepted through the response cycle. A request raised while busy is ignored.
- R11: done and fault are never high together, and each is high for exactly one cycle per walk.
- R12: While mem_req is high and not yet acknowledged, mem_addr, mem_we and mem_wdata hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a walk (taken only when not busy) |
| req_va | input | 32 | Virtual address to translate |
| req_store | input | 1 | 1 = store access, 0 = load access |
| tbl_base | input | 32 | First-level table base (bits 31:12 used) |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse: translation succeeded |
| fault | output | 1 | One-cycle pulse: translation failed |
| fault_code | output | 2 | 0 none, 1 invalid, 2 not resident, 3 store not allowed |
| phys_addr | output | 32 | Translated address, valid with done |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 32 | Byte address of the table word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge from memory |
| mem_rdata | input | 32 | Read data, valid with mem_ack |

## Verification
The bench runs a sequence of walks through one shared second-level table, so that the same leaf is seen both clean and dirty. If the walker skipped the dirty write-back, or wrote it again on the second store, the logged write count would be wrong.

Each fault type is reached at both levels:
- A walker that keeps going after a bad first-level word shows a second read in the log.
- A walker that mixes up invalid and not-resident returns the wrong fault code.
- A walker that drops the store check returns a translation for a page that does not allow stores.

Other stimulus:
- Memory latency changes between walks. A walker that does not hold its request steady, or that ignores the acknowledge, then logs wrong addresses.
- A request raised in the middle of a walk must leave both the result and the read count unchanged.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned OFF_W  = 12;
  localparam int unsigned L1_W   = 10;
  localparam int unsigned L2_W   = 10;
  localparam int unsigned PN_W   = VA_W - OFF_W;
  localparam int unsigned ENT_SH = 2;          // 4-byte table words

  localparam int unsigned BIT_V = 0;
  localparam int unsigned BIT_P = 1;
  localparam int unsigned BIT_W = 2;
  localparam int unsigned BIT_D = 3;
  localparam int unsigned FLG_W = 4;

  typedef enum logic [1:0] {
    FC_NONE    = 2'd0,
    FC_INVALID = 2'd1,
    FC_ABSENT  = 2'd2,
    FC_PERM    = 2'd3
  } fcode_e;

  function automatic logic [PN_W-1:0] idx_hi(input logic [VA_W-1:0] va);
    return PN_W'(va[VA_W-1 -: L1_W]);
  endfunction

  function automatic logic [PN_W-1:0] idx_lo(input logic [VA_W-1:0] va);
    return PN_W'(va[OFF_W +: L2_W]);
  endfunction

  function automatic logic [VA_W-1:0] slot_addr(input logic [PN_W-1:0] tbl_pn,
                                                input logic [PN_W-1:0] idx);
    return {tbl_pn, {OFF_W{1'b0}}} + (VA_W'(idx) << ENT_SH);
  endfunction

  function automatic logic [VA_W-1:0] join_pa(input logic [PN_W-1:0] pn,
                                              input logic [VA_W-1:0] va);
    return {pn, va[OFF_W-1:0]};
  endfunction
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
  import ptw_pkg::*;
(
  input  logic            second,
  input  logic [PN_W-1:0] root_pn,
  input  logic [PN_W-1:0] mid_pn,
  input  logic [VA_W-1:0] va,
  output logic [VA_W-1:0] addr
);
  always_comb begin
    if (second) addr = slot_addr(mid_pn, idx_lo(va));
    else        addr = slot_addr(root_pn, idx_hi(va));
  end
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
  import ptw_pkg::*;
(
  input  logic [FLG_W-1:0] flags,
  input  logic             leaf,
  input  logic             store,
  output fcode_e           code,
  output logic             need_wb
);
  always_comb begin
    code    = FC_NONE;
    need_wb = 1'b0;
    if (!flags[BIT_V])                        code = FC_INVALID;
    else if (!flags[BIT_P])                   code = FC_ABSENT;
    else if (leaf && store && !flags[BIT_W])  code = FC_PERM;
    else if (leaf && store && !flags[BIT_D])  need_wb = 1'b1;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [31:0] req_va,
  input  logic        req_store,
  input  logic [31:0] tbl_base,
  output logic        busy,
  output logic        done,
  output logic        fault,
  output logic [1:0]  fault_code,
  output logic [31:0] phys_addr,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_L1, S_L2, S_WB, S_OK, S_FLT} st_e;

  st_e             st;
  logic [VA_W-1:0] va_q;
  logic            store_q;
  logic [PN_W-1:0] root_q;
  logic [PN_W-1:0] mid_q;
  logic [VA_W-1:0] leaf_q;
  logic [VA_W-1:0] pa_q;
  fcode_e          code_q;

  fcode_e          ev_code;
  logic            ev_wb;
  logic [VA_W-1:0] slot;

  // named events for the checker
  logic walk_start, l1_fault, leaf_fault, wb_issue;

  assign walk_start = (st == S_IDLE) && req_valid;
  assign l1_fault   = (st == S_L1) && mem_ack && (ev_code != FC_NONE);
  assign leaf_fault = (st == S_L2) && mem_ack && (ev_code != FC_NONE);
  assign wb_issue   = (st == S_L2) && mem_ack && (ev_code == FC_NONE) && ev_wb;

  ptw_addr_gen u_addr (
    .second (st != S_L1),
    .root_pn(root_q),
    .mid_pn (mid_q),
    .va     (va_q),
    .addr   (slot)
  );

  ptw_pte_eval u_eval (
    .flags  (mem_rdata[FLG_W-1:0]),
    .leaf   (st == S_L2),
    .store  (store_q),
    .code   (ev_code),
    .need_wb(ev_wb)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      va_q    <= '0;
      store_q <= 1'b0;
      root_q  <= '0;
      mid_q   <= '0;
      leaf_q  <= '0;
      pa_q    <= '0;
      code_q  <= FC_NONE;
    end else begin
      unique case (st)
        S_IDLE: if (req_valid) begin
          va_q    <= req_va;
          store_q <= req_store;
          root_q  <= tbl_base[VA_W-1:OFF_W];
          st      <= S_L1;
        end
        S_L1: if (mem_ack) begin
          mid_q <= mem_rdata[VA_W-1:OFF_W];
          if (ev_code != FC_NONE) begin
            code_q <= ev_code;
            st     <= S_FLT;
          end else begin
            st <= S_L2;
          end
        end
        S_L2: if (mem_ack) begin
          leaf_q <= mem_rdata;
          if (ev_code != FC_NONE) begin
            code_q <= ev_code;
            st     <= S_FLT;
          end else if (ev_wb) begin
            st <= S_WB;
          end else begin
            code_q <= FC_NONE;
            pa_q   <= join_pa(mem_rdata[VA_W-1:OFF_W], va_q);
            st     <= S_OK;
          end
        end
        S_WB: if (mem_ack) begin
          code_q <= FC_NONE;
          pa_q   <= join_pa(leaf_q[VA_W-1:OFF_W], va_q);
          st     <= S_OK;
        end
        S_OK:    st <= S_IDLE;
        S_FLT:   st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy       = (st != S_IDLE);
  assign done       = (st == S_OK);
  assign fault      = (st == S_FLT);
  assign fault_code = code_q;
  assign phys_addr  = pa_q;
  assign mem_req    = (st == S_L1) || (st == S_L2) || (st == S_WB);
  assign mem_we     = (st == S_WB);
  assign mem_addr   = slot;
  assign mem_wdata  = leaf_q | (VA_W'(1) << BIT_D);
endmodule

// File: rtl/ptw_checker.sv
module ptw_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        fault,
  input logic [1:0]  fault_code,
  input logic        mem_req,
  input logic        mem_we,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic [31:0] mem_wdata,
  input logic        l1_fault,
  input logic        wb_issue
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !done && !fault);

  a_r5_l1_stop: assert property (@(posedge clk) disable iff (!rst_n)
    l1_fault |=> fault && !mem_req && (fault_code != 2'd0));

  a_r8_wb_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    wb_issue |=> mem_req && mem_we && mem_wdata[3]);

  a_r10_busy_resp: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |-> busy);

  a_r11_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r11_fault_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    fault |=> !fault);

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata));
endmodule

bind pt_walker ptw_checker chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .fault     (fault),
  .fault_code(fault_code),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .l1_fault  (l1_fault),
  .wb_issue  (wb_issue)
);

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_store = 1'b0;
  logic [31:0] tbl_base = 32'h0001_0000;
  logic        busy, done, fault, mem_req, mem_we;
  logic [1:0]  fault_code;
  logic [31:0] phys_addr, mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #4 clk = ~clk;   // 125 MHz

  pt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_store(req_store), .tbl_base(tbl_base), .busy(busy), .done(done),
    .fault(fault), .fault_code(fault_code), .phys_addr(phys_addr),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // ---------------- memory model ----------------
  logic [31:0] mem [bit [31:0]];
  int          lat = 0;
  int          cnt = 0;
  int          nrd = 0;
  int          nwr = 0;
  logic [31:0] rd_addr [4];
  logic [31:0] wr_addr, wr_data;

  function automatic logic [31:0] peek(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (cnt >= lat) begin
        cnt = 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          mem[mem_addr] = mem_wdata;
          wr_addr = mem_addr;
          wr_data = mem_wdata;
          nwr++;
        end else begin
          mem_rdata <= peek(mem_addr);
          if (nrd < 4) rd_addr[nrd] = mem_addr;
          nrd++;
        end
      end else begin
        cnt++;
      end
    end
  end

  // ---------------- checking ----------------
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic        st;
    logic [1:0]  code;
    logic [31:0] pa;
    logic [3:0]  reads;
    logic [3:0]  writes;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{32'hFC51908B, 1'b0, 2'd0, 32'h0015208B, 4'd2, 4'd0},
    '{32'hFC51908B, 1'b1, 2'd3, 32'h0,        4'd2, 4'd0},
    '{32'hFC51A123, 1'b1, 2'd0, 32'h00345123, 4'd2, 4'd1},
    '{32'hFC51A123, 1'b1, 2'd0, 32'h00345123, 4'd2, 4'd0},
    '{32'hFC51A456, 1'b0, 2'd0, 32'h00345456, 4'd2, 4'd0},
    '{32'hFC51B000, 1'b0, 2'd2, 32'h0,        4'd2, 4'd0},
    '{32'hFC51C000, 1'b1, 2'd1, 32'h0,        4'd2, 4'd0},
    '{32'h00000ABC, 1'b0, 2'd1, 32'h0,        4'd1, 4'd0},
    '{32'h00400000, 1'b1, 2'd2, 32'h0,        4'd1, 4'd0},
    '{32'h00805FFF, 1'b1, 2'd0, 32'h0ABCDFFF, 4'd2, 4'd0}
  };

  logic        g_done, g_fault;
  logic [1:0]  g_code;
  logic [31:0] g_pa;

  task automatic walk(input logic [31:0] va, input logic st);
    int t;
    nrd = 0; nwr = 0;
    @(negedge clk);
    while (busy) @(negedge clk);
    req_valid = 1'b1; req_va = va; req_store = st;
    @(negedge clk);
    req_valid = 1'b0;
    chk(busy === 1'b1, "R10 busy after accept", 32'(busy), 32'd1);
    t = 0;
    while (!(done || fault) && t < 300) begin @(negedge clk); t++; end
    g_done = done; g_fault = fault; g_code = fault_code; g_pa = phys_addr;
    chk(!(done && fault), "R11 done/fault exclusive", {done, fault}, 32'd0);
    @(negedge clk);
    chk(!done && !fault, "R11 single-cycle response", {done, fault}, 32'd0);
  endtask

  initial begin : watchdog
    #(8 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] l1a, l2a;
    // table contents (base 0x10000)
    mem[32'h00010FC4] = 32'h00020003;
    mem[32'h00020464] = 32'h00152003;
    mem[32'h00020468] = 32'h00345007;
    mem[32'h0002046C] = 32'h00000001;
    mem[32'h00010004] = 32'h00030001;
    mem[32'h00010008] = 32'h00030003;
    mem[32'h00030014] = 32'h0ABCD00F;

    repeat (3) @(negedge clk);
    chk(!busy && !done && !fault && !mem_req, "R1 state in reset",
        {busy, done, fault, mem_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!busy && !done && !fault && !mem_req, "R1 idle after reset",
        {busy, done, fault, mem_req}, 32'd0);

    foreach (VECS[i]) begin
      lat = i % 3;
      walk(VECS[i].va, VECS[i].st);
      if (VECS[i].code == 2'd0) begin
        chk(g_done === 1'b1, "R2 done raised", 32'(g_done), 32'd1);
        chk(g_pa === VECS[i].pa, "R2 physical address", g_pa, VECS[i].pa);
      end else begin
        chk(g_fault === 1'b1, "R5/R6/R7 fault raised", 32'(g_fault), 32'd1);
        chk(g_code === VECS[i].code, "R5 R6 R7 fault code", 32'(g_code),
            32'(VECS[i].code));
      end
      chk(nrd == int'(VECS[i].reads), "R5 read count", nrd, VECS[i].reads);
      chk(nwr == int'(VECS[i].writes), "R7 R8 R9 write count", nwr,
          VECS[i].writes);
      l1a = {tbl_base[31:12], 12'h0} + {20'h0, VECS[i].va[31:22], 2'b00};
      chk(rd_addr[0] === l1a, "R3 R12 first read address", rd_addr[0], l1a);
      if (VECS[i].reads == 4'd2) begin
        l2a = {peek(l1a) & 32'hFFFFF000} + {20'h0, VECS[i].va[21:12], 2'b00};
        chk(rd_addr[1] === l2a, "R4 R12 second read address", rd_addr[1], l2a);
      end
      if (i == 2) begin
        chk(wr_addr === 32'h00020468, "R8 write-back address", wr_addr,
            32'h00020468);
        chk(wr_data === 32'h0034500F, "R8 write-back data", wr_data,
            32'h0034500F);
      end
    end
    chk(peek(32'h00020464) === 32'h00152003, "R7 leaf untouched",
        peek(32'h00020464), 32'h00152003);

    // R10: a request during a walk is ignored
    lat = 3;
    nrd = 0; nwr = 0;
    @(negedge clk);
    req_valid = 1'b1; req_va = 32'hFC51908B; req_store = 1'b0;
    @(negedge clk);
    req_va = 32'h00000ABC; req_store = 1'b1;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    while (!(done || fault)) @(negedge clk);
    chk(done && phys_addr === 32'h0015208B, "R10 busy request ignored",
        phys_addr, 32'h0015208B);
    chk(nrd == 2, "R10 no extra reads", nrd, 2);
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req, "R10 no second walk", {busy, mem_req}, 32'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule